// File: doc/BRIEF.md
# Per-Set LRU Replacement Controller

This block keeps the least-recently-used ordering of the ways in one cache set and names the way that the next refill will evict. A set-associative cache places one instance beside each set. A fully-associative cache uses a single instance for the whole array. Tag storage, data storage and hit detection sit outside the block. The block only sees which way was touched and what kind of command was issued.

A command is four control bits: tag access, access-is-write, invalidate and replace. With the hit-way index, they select one of four actions. A read hit or a write hit promotes the hit way to most recently used. An invalidating hit demotes the hit way so that it becomes the next eviction candidate. A replace evicts the way on the output, and that way then counts as freshly used. Every other encoding leaves the state alone.

Recency is held as an ordered list of way indices, with the least recently used way at the head. The output `replace_way` is the head entry, read combinationally from the registers. All state changes take effect on the rising clock edge that samples the command.

Top module: `lru_set_policy`

## Requirements
- R1: After a cycle with `rst_n` low, the order runs from way 0 (least recent) up to way NUM_WAYS-1 (most recent). `replace_way` reads 0, and successive replace commands evict 0, 1, 2, ... in turn.
- R2: With `tag_access`=0 and `replace`=0, the ordering does not change, whatever the other inputs are.
- R3: A read hit (`tag_access`=1, `access_is_write`=0, `invalidate`=0, `replace`=0) moves `hit_way` to the most-recently-used position. The relative order of the other ways is kept.
- R4: A write hit (`tag_access`=1, `access_is_write`=1, `invalidate`=0, `replace`=0) has the same effect as a read hit.
- R5: An invalidating hit (`tag_access`=1, `invalidate`=1, `replace`=0, either value of `access_is_write`) moves `hit_way` to the least-recently-used position. `replace_way` equals that way one cycle later, and the other ways keep their relative order.
- R6: A replace (`tag_access`=0, `invalidate`=0, `replace`=1) evicts the way shown on `replace_way` and moves it to the most-recently-used position. The next-oldest way becomes the new candidate.
- R7: The encodings with `tag_access`=1 and `replace`=1, and the encoding with `tag_access`=0, `invalidate`=1 and `replace`=1, are no-ops. The ordering does not change.
- R8: The ordering always holds every way index exactly once, so `replace_way` is always a valid way below NUM_WAYS.
- R9: During a replace command, `hit_way` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| tag_access | input | 1 | A tag lookup hit `hit_way` this cycle |
| access_is_write | input | 1 | 1 for a write access, 0 for a read; does not affect recency |
| invalidate | input | 1 | The hit line is being invalidated |
| replace | input | 1 | Evict and refill the way on `replace_way` |
| hit_way | input | WAY_W | Way addressed by a tag-access command |
| replace_way | output | WAY_W | Way the next replace command will evict |

## Verification
A corrupt ordering reaches the port only through the head entry. A slot deep in the list can stay hidden until enough replaces or demotions bring it to the head, which takes up to NUM_WAYS commands. For this reason the bench reads the whole list after each command under test: it issues NUM_WAYS replace commands, and these rotate every entry past `replace_way` and bring the list back to its starting order. A lost or duplicated way index then shows within those NUM_WAYS cycles, either as a wrong candidate or as a way that never appears.

// File: rtl/lru_pkg.sv
// Shared types for the per-set LRU replacement controller.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package lru_pkg;

    // Decoded recency action applied to the ordered way list.
    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,   // leave order unchanged
        OP_TOUCH  = 2'd1,   // move hit way to MRU tail
        OP_DEMOTE = 2'd2,   // move hit way to LRU head
        OP_REFILL = 2'd3    // move head way to MRU tail
    } lru_op_e;

endpackage

// File: rtl/lru_cmd_decode.sv
// Decodes the four command bits into one recency action.
// Assumes: the access direction bit never changes recency, so it is not
// an input here; every encoding outside the defined four maps to OP_IDLE.
module lru_cmd_decode
    import lru_pkg::*;
(
    input  logic    tag_access,
    input  logic    invalidate,
    input  logic    replace,
    output lru_op_e op
);

    // Purpose: map the command truth table onto an action.
    always_comb begin
        op = OP_IDLE;
        if (tag_access && !replace) begin
            op = invalidate ? OP_DEMOTE : OP_TOUCH;
        end else if (!tag_access && !invalidate && replace) begin
            op = OP_REFILL;
        end
    end

endmodule

// File: rtl/lru_locate.sv
// Finds a way index inside the ordered list and produces position masks.
// Assumes: the list is a permutation, so at most one slot matches.
// at_or_after[i] is set when the match lies at slot i or lower;
// at_or_before[i] is set when the match lies at slot i or higher.
module lru_locate #(
    parameter int NUM_WAYS = 4,
    parameter int WAY_W    = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS*WAY_W-1:0] order_flat,
    input  logic [WAY_W-1:0]          target,
    output logic                      found,
    output logic [NUM_WAYS-1:0]       at_or_after,
    output logic [NUM_WAYS-1:0]       at_or_before
);

    logic [NUM_WAYS-1:0] match;

    // Purpose: compare every slot against the target way.
    generate
        for (genvar g = 0; g < NUM_WAYS; g++) begin : g_cmp
            assign match[g] = (order_flat[g*WAY_W +: WAY_W] == target);
        end
    endgenerate

    // Purpose: prefix and suffix OR of the match vector.
    always_comb begin
        at_or_after[0] = match[0];
        for (int i = 1; i < NUM_WAYS; i++) begin
            at_or_after[i] = at_or_after[i-1] | match[i];
        end
        at_or_before[NUM_WAYS-1] = match[NUM_WAYS-1];
        for (int i = NUM_WAYS - 2; i >= 0; i--) begin
            at_or_before[i] = at_or_before[i+1] | match[i];
        end
    end

    assign found = |match;

endmodule

// File: rtl/lru_order_list.sv
// Ordered list of way indices: slot 0 is least recently used, slot
// NUM_WAYS-1 most recently used. Applies one action per clock.
// Assumes: synchronous active-low reset; NUM_WAYS >= 2.
module lru_order_list
    import lru_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    parameter int WAY_W    = $clog2(NUM_WAYS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  lru_op_e                   op,
    input  logic [WAY_W-1:0]          hit_way,
    output logic [WAY_W-1:0]          head_way,
    output logic [NUM_WAYS*WAY_W-1:0] order_flat
);

    localparam int LAST = NUM_WAYS - 1;

    logic [WAY_W-1:0]    order_q [NUM_WAYS];
    logic [WAY_W-1:0]    order_d [NUM_WAYS];
    logic [WAY_W-1:0]    target;
    logic                found;
    logic [NUM_WAYS-1:0] at_or_after;
    logic [NUM_WAYS-1:0] at_or_before;

    // Purpose: flatten the list for the locator and the outside view.
    generate
        for (genvar g = 0; g < NUM_WAYS; g++) begin : g_flat
            assign order_flat[g*WAY_W +: WAY_W] = order_q[g];
        end
    endgenerate

    // Purpose: a refill moves the current head; otherwise the hit way.
    assign target   = (op == OP_REFILL) ? order_q[0] : hit_way;
    assign head_way = order_q[0];

    lru_locate #(
        .NUM_WAYS (NUM_WAYS),
        .WAY_W    (WAY_W)
    ) u_locate (
        .order_flat   (order_flat),
        .target       (target),
        .found        (found),
        .at_or_after  (at_or_after),
        .at_or_before (at_or_before)
    );

    // Purpose: compute the next list for the selected action.
    always_comb begin
        for (int i = 0; i < NUM_WAYS; i++) begin
            order_d[i] = order_q[i];
        end
        unique case (op)
            OP_TOUCH, OP_REFILL: begin
                for (int i = 0; i < LAST; i++) begin
                    if (at_or_after[i]) order_d[i] = order_q[i+1];
                end
                if (found) order_d[LAST] = target;
            end
            OP_DEMOTE: begin
                for (int i = 1; i < NUM_WAYS; i++) begin
                    if (at_or_before[i]) order_d[i] = order_q[i-1];
                end
                if (found) order_d[0] = target;
            end
            default: ;
        endcase
    end

    // Purpose: hold the list; reset to ascending way order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WAYS; i++) begin
                order_q[i] <= WAY_W'(i);
            end
        end else begin
            for (int i = 0; i < NUM_WAYS; i++) begin
                order_q[i] <= order_d[i];
            end
        end
    end

endmodule

// File: rtl/lru_set_policy.sv
// Top of the per-set LRU replacement controller. One instance per set.
// Assumes: at most one command per cycle; hit_way is a valid way.
module lru_set_policy
    import lru_pkg::*;
#(
    parameter  int NUM_WAYS = 4,
    localparam int WAY_W    = $clog2(NUM_WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tag_access,
    input  logic             access_is_write,
    input  logic             invalidate,
    input  logic             replace,
    input  logic [WAY_W-1:0] hit_way,
    output logic [WAY_W-1:0] replace_way
);

    lru_op_e                   op;
    logic [NUM_WAYS*WAY_W-1:0] order_flat;
    logic                      unused_dir;

    // Purpose: the access direction never changes recency.
    assign unused_dir = access_is_write;

    lru_cmd_decode u_decode (
        .tag_access (tag_access),
        .invalidate (invalidate),
        .replace    (replace),
        .op         (op)
    );

    lru_order_list #(
        .NUM_WAYS (NUM_WAYS),
        .WAY_W    (WAY_W)
    ) u_list (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .hit_way    (hit_way),
        .head_way   (replace_way),
        .order_flat (order_flat)
    );

endmodule

// File: rtl/lru_set_policy_chk.sv
// Property checker for lru_set_policy, attached by bind below.
// Assumes: NUM_WAYS >= 2 so a promoted way is never the head.
module lru_set_policy_chk #(
    parameter  int NUM_WAYS = 4,
    localparam int WAY_W    = $clog2(NUM_WAYS)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      tag_access,
    input logic                      invalidate,
    input logic                      replace,
    input logic [WAY_W-1:0]          hit_way,
    input logic [WAY_W-1:0]          replace_way,
    input logic [NUM_WAYS*WAY_W-1:0] order_flat
);

    logic [NUM_WAYS-1:0] seen;

    // Purpose: mark every way index present in the list.
    always_comb begin
        seen = '0;
        for (int i = 0; i < NUM_WAYS; i++) begin
            for (int w = 0; w < NUM_WAYS; w++) begin
                if (order_flat[i*WAY_W +: WAY_W] == WAY_W'(w)) seen[w] = 1'b1;
            end
        end
    end

    AST_RESET_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> replace_way == '0); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tag_access && !replace) |=> $stable(order_flat)); // R2
    AST_HIT_LEAVES_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_access && !invalidate && !replace) |=> replace_way != $past(hit_way)); // R3
    AST_INVAL_TO_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_access && invalidate && !replace) |=> replace_way == $past(hit_way)); // R5
    AST_REFILL_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tag_access && !invalidate && replace) |=> replace_way != $past(replace_way)); // R6
    AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((tag_access && replace) || (!tag_access && invalidate && replace))
        |=> $stable(order_flat)); // R7
    AST_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
        seen == {NUM_WAYS{1'b1}}); // R8

endmodule

bind lru_set_policy lru_set_policy_chk #(.NUM_WAYS(NUM_WAYS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tag_access  (tag_access),
    .invalidate  (invalidate),
    .replace     (replace),
    .hit_way     (hit_way),
    .replace_way (replace_way),
    .order_flat  (order_flat)
);

// File: tb/tb_lru_set_policy.sv
`timescale 1ns/1ps
// Bench: sweeps every command encoding and hit way from a scrambled
// order, reads the full list back through replace rotations, then runs
// a long pseudo-random sequence. Model keeps a rank per way (0 = LRU).
module tb_lru_set_policy;
    localparam int N = 4;
    localparam int W = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tag_access = 1'b0;
    logic         access_is_write = 1'b0;
    logic         invalidate = 1'b0;
    logic         replace = 1'b0;
    logic [W-1:0] hit_way = '0;
    logic [W-1:0] replace_way;

    int total = 0;
    int bad   = 0;
    int rank [N];
    logic [31:0] lfsr = 32'h1ACE_5EED;

    always #2.5 clk = ~clk;

    lru_set_policy #(.NUM_WAYS(N)) dut (
        .clk (clk), .rst_n (rst_n), .tag_access (tag_access),
        .access_is_write (access_is_write), .invalidate (invalidate),
        .replace (replace), .hit_way (hit_way), .replace_way (replace_way)
    );

    function automatic int model_head();
        for (int w = 0; w < N; w++) if (rank[w] == 0) return w;
        return -1;
    endfunction

    function automatic void model_promote(int w);
        for (int k = 0; k < N; k++) if (rank[k] > rank[w]) rank[k]--;
        rank[w] = N - 1;
    endfunction

    function automatic void model_demote(int w);
        for (int k = 0; k < N; k++) if (rank[k] < rank[w]) rank[k]++;
        rank[w] = 0;
    endfunction

    function automatic string req_of(logic t, logic rw, logic i, logic r);
        if (!t && !r) return "R2";
        if (t && !i && !r) return rw ? "R4" : "R3";
        if (t && i && !r) return "R5";
        if (!t && !i && r) return "R6";
        return "R7";
    endfunction

    task automatic check(string req);
        total++;
        if (int'(replace_way) != model_head()) begin
            bad++;
            $display("FAIL %s: replace_way=%0d expected=%0d", req, replace_way, model_head());
        end
    endtask

    task automatic apply(logic t, logic rw, logic i, logic r, int w, string req);
        @(negedge clk);
        tag_access = t; access_is_write = rw; invalidate = i; replace = r;
        hit_way = W'(w);
        @(posedge clk);
        #1;
        if (t && !r) begin
            if (i) model_demote(w); else model_promote(w);
        end else if (!t && !i && r) begin
            model_promote(model_head());
        end
        check(req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tag_access = 0; invalidate = 0; replace = 0;
        @(posedge clk); @(posedge clk);
        for (int w = 0; w < N; w++) rank[w] = w;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Read the whole order through N refills; order returns to start.
    task automatic dump(string req);
        for (int k = 0; k < N; k++) apply(0, 0, 0, 1, k ^ 1, req);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        bad++;
        $display("FAIL watchdog: run did not finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        #1; check("R1");              // reset head is way 0
        dump("R1");                   // evicts 0,1,2,3 in turn

        // Sweep all 16 encodings x all hit ways from a scrambled order.
        for (int c = 0; c < 16; c++) begin
            for (int w = 0; w < N; w++) begin
                do_reset();
                apply(1, 0, 0, 0, 2, "R3");
                apply(1, 1, 0, 0, 0, "R4");
                apply(1, 0, 0, 0, 3, "R3");
                apply(1, 1, 0, 0, 1, "R4");
                apply(c[3], c[2], c[1], c[0], w,
                      req_of(c[3], c[2], c[1], c[0]));
                dump(req_of(c[3], c[2], c[1], c[0]));
            end
        end

        // R9: replaces with every hit_way value give the same rotation.
        do_reset();
        for (int k = 0; k < 3 * N; k++) apply(0, 0, 0, 1, (k * 3) % N, "R9");

        // Long pseudo-random command stream, order read back periodically.
        do_reset();
        for (int s = 0; s < 3000; s++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            apply(lfsr[3], lfsr[4], lfsr[5] & lfsr[6], lfsr[7] & ~lfsr[3],
                  int'(lfsr[9:8]),
                  req_of(lfsr[3], lfsr[4], lfsr[5] & lfsr[6], lfsr[7] & ~lfsr[3]));
            if (s % 97 == 0) dump("R8");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule